// File: doc/BRIEF.md
# Three-Bit-Coded 32-bit Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It takes two operands of `WIDTH` bits (32 by default) and a 3-bit operation code. It returns a result of the same width and a flag that is high when that result is all zeros. The six defined operations are addition, subtraction, bitwise AND, bitwise OR, bitwise XOR and a signed set-less-than. The set-less-than places a single 0 or 1 in the least significant bit of the result.

The block has no clock and no state, so the result follows the inputs within the same cycle. Addition, subtraction and the comparison can share one carry chain, and a parameter chooses that variant. Another parameter chooses whether the comparison is derived from the difference or built as a separate signed comparator. The two codes that name no operation give a zero result.

Top module: `alu3_core`

## Requirements
- R1: Code 3'b010 returns operand A plus operand B, wrapped modulo 2^WIDTH with no overflow indication.
- R2: Code 3'b110 returns operand A minus operand B, wrapped modulo 2^WIDTH.
- R3: Code 3'b000 returns the bitwise AND of the operands.
- R4: Code 3'b001 returns the bitwise OR of the operands.
- R5: Code 3'b011 returns the bitwise XOR of the operands.
- R6: Code 3'b111 compares the operands as signed two's-complement numbers. It returns 1 in bit 0, with every upper bit 0, when A < B, and returns all zeros otherwise.
- R7: Codes 3'b100 and 3'b101 return an all-zero result, whatever the operands are.
- R8: The zero flag is 1 exactly when every bit of the result is 0, for every code.
- R9: Both outputs depend only on the present inputs. A change of any input is visible at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code |
| opa_i | input | WIDTH | First operand (A) |
| opb_i | input | WIDTH | Second operand (B) |
| res_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when res_o is all zeros |

## Verification
Every result and the zero flag are due in the same cycle as the stimulus, zero cycles later, because no register lies between the ports. The bench applies each operand set just after a rising clock edge and compares at the following falling edge, once the combinational paths have settled. For R9 it also changes the inputs between edges and checks after a short delay, with no clock edge in between. The signed boundary 0x7FFFFFFF against 0x80000000 and a subtraction of equal operands are among the directed vectors.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

   typedef enum logic [2:0] {
      OP_AND  = 3'b000,
      OP_OR   = 3'b001,
      OP_ADD  = 3'b010,
      OP_XOR  = 3'b011,
      OP_RSV4 = 3'b100,
      OP_RSV5 = 3'b101,
      OP_SUB  = 3'b110,
      OP_SLT  = 3'b111
   } alu_op_e;

   localparam int unsigned OP_BITS = 3;

endpackage

// File: rtl/alu3_addsub.sv
module alu3_addsub #(
   parameter int unsigned WIDTH  = 32,
   parameter bit          SHARED = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o
);

   generate
      if (SHARED) begin : g_shared
         // one carry chain: invert B and inject a carry for subtraction
         logic [WIDTH-1:0] b_eff;
         assign b_eff = b_i ^ {WIDTH{sub_i}};
         assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
      end else begin : g_split
         logic [WIDTH-1:0] add_r;
         logic [WIDTH-1:0] sub_r;
         assign add_r = a_i + b_i;
         assign sub_r = a_i - b_i;
         assign sum_o = sub_i ? sub_r : add_r;
      end
   endgenerate

endmodule

// File: rtl/alu3_bitwise.sv
module alu3_bitwise #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       sel_i,
   output logic [WIDTH-1:0] y_o
);

   always_comb begin
      unique case (sel_i)
         2'b00:   y_o = a_i & b_i;
         2'b01:   y_o = a_i | b_i;
         2'b11:   y_o = a_i ^ b_i;
         default: y_o = '0;
      endcase
   end

endmodule

// File: rtl/alu3_lessthan.sv
module alu3_lessthan #(
   parameter int unsigned WIDTH    = 32,
   parameter bit          VIA_DIFF = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [WIDTH-1:0] diff_i,
   output logic             lt_o
);

   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (VIA_DIFF) begin : g_from_diff
         // signed less-than = sign of A-B corrected by signed overflow
         logic ovf;
         logic [MSB-1:0] low_unused;
         assign ovf        = (a_i[MSB] ^ b_i[MSB]) & (diff_i[MSB] ^ a_i[MSB]);
         assign lt_o       = diff_i[MSB] ^ ovf;
         assign low_unused = diff_i[MSB-1:0];
      end else begin : g_direct
         logic diff_unused;
         assign diff_unused = ^diff_i;
         assign lt_o        = $signed(a_i) < $signed(b_i);
      end
   endgenerate

endmodule

// File: rtl/alu3_core.sv
module alu3_core
   import alu3_pkg::*;
#(
   parameter int unsigned WIDTH        = 32,
   parameter bit          SHARED_ADDER = 1'b1,
   parameter bit          SLT_VIA_DIFF = 1'b1
) (
   input  logic [OP_BITS-1:0] op_i,
   input  logic [WIDTH-1:0]   opa_i,
   input  logic [WIDTH-1:0]   opb_i,
   output logic [WIDTH-1:0]   res_o,
   output logic               zero_o
);

   generate
      if (WIDTH < 2) begin : g_width_check
         $error("alu3_core: WIDTH must be at least 2");
      end
      if (SLT_VIA_DIFF && !SHARED_ADDER && WIDTH > 64) begin : g_width_note
         $info("alu3_core: wide split adder with derived compare");
      end
   endgenerate

   alu_op_e          op_e;
   logic [WIDTH-1:0] sum_w;
   logic [WIDTH-1:0] bit_w;
   logic             lt_w;

   assign op_e = alu_op_e'(op_i);

   // bit 2 of the code is set for subtraction and for the compare
   alu3_addsub #(.WIDTH(WIDTH), .SHARED(SHARED_ADDER)) u_addsub (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .sub_i (op_i[2]),
      .sum_o (sum_w)
   );

   alu3_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .sel_i (op_i[1:0]),
      .y_o   (bit_w)
   );

   alu3_lessthan #(.WIDTH(WIDTH), .VIA_DIFF(SLT_VIA_DIFF)) u_lt (
      .a_i    (opa_i),
      .b_i    (opb_i),
      .diff_i (sum_w),
      .lt_o   (lt_w)
   );

   always_comb begin
      unique case (op_e)
         OP_AND, OP_OR, OP_XOR: res_o = bit_w;
         OP_ADD, OP_SUB:        res_o = sum_w;
         OP_SLT:                res_o = {{(WIDTH-1){1'b0}}, lt_w};
         default:               res_o = '0;
      endcase
   end

   assign zero_o = ~|res_o;

   // ---------------- assertions ----------------
   always_comb begin
      if (op_e == OP_ADD) begin
         a_r1_add_inverse: assert (res_o - opb_i == opa_i)
            else $error("R1: sum minus B differs from A");
      end
      if (op_e == OP_SUB) begin
         a_r2_sub_inverse: assert (res_o + opb_i == opa_i)
            else $error("R2: difference plus B differs from A");
      end
      if (op_e == OP_AND) begin
         a_r3_and_subset: assert (((res_o & ~opa_i) | (res_o & ~opb_i)) == '0)
            else $error("R3: AND result has bits outside the operands");
      end
      if (op_e == OP_SLT) begin
         a_r6_slt_boolean: assert (res_o[WIDTH-1:1] == '0)
            else $error("R6: compare result not zero-extended");
      end
      if (op_e == OP_RSV4 || op_e == OP_RSV5) begin
         a_r7_unused_zero: assert (res_o == '0 && zero_o)
            else $error("R7: unused code gave nonzero result");
      end
      a_r8_zero_flag: assert (zero_o == (res_o == '0))
         else $error("R8: zero flag inconsistent with result");
   end

endmodule

// File: tb/alu3_core_test.sv
module alu3_core_test;

   localparam int W     = 32;
   localparam int NVEC  = 18;
   localparam int NRAND = 400;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [2:0]   op;
   logic [W-1:0] a;
   logic [W-1:0] b;
   logic [W-1:0] res;
   logic         zero;

   int compared   = 0;
   int mismatched = 0;
   bit finished   = 0;

   always #4 clk = ~clk;   // 125 MHz

   alu3_core #(.WIDTH(W)) uut (
      .op_i   (op),
      .opa_i  (a),
      .opb_i  (b),
      .res_o  (res),
      .zero_o (zero)
   );

   // {code, A, B, expected result}
   localparam logic [98:0] VEC [NVEC] = '{
      {3'b010, 32'h0000_0002, 32'h0000_0003, 32'h0000_0005},
      {3'b010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
      {3'b010, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
      {3'b110, 32'h0000_0005, 32'h0000_0003, 32'h0000_0002},
      {3'b110, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF},
      {3'b110, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000},
      {3'b000, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000},
      {3'b000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
      {3'b001, 32'hF0F0_F0F0, 32'h0F0F_0000, 32'hFFFF_F0F0},
      {3'b011, 32'hAAAA_AAAA, 32'hFFFF_0000, 32'h5555_AAAA},
      {3'b011, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0000_0000},
      {3'b111, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000},
      {3'b111, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001},
      {3'b111, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
      {3'b111, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000},
      {3'b111, 32'h0000_0003, 32'h0000_0004, 32'h0000_0001},
      {3'b100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
      {3'b101, 32'h0000_0012, 32'h0000_0034, 32'h0000_0000}
   };

   function automatic string tag_of(input logic [2:0] c);
      case (c)
         3'b010:  return "R1";
         3'b110:  return "R2";
         3'b000:  return "R3";
         3'b001:  return "R4";
         3'b011:  return "R5";
         3'b111:  return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic logic [W-1:0] model(input logic [2:0] c,
                                          input logic [W-1:0] x,
                                          input logic [W-1:0] y);
      logic [W-1:0] r;
      case (c)
         3'b010:  r = x + y;
         3'b110:  r = x - y;
         3'b000:  r = x & y;
         3'b001:  r = x | y;
         3'b011:  r = x ^ y;
         3'b111:  begin
            if (x[W-1] != y[W-1]) r = {31'd0, x[W-1]};
            else                  r = {31'd0, (x < y)};
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] exp_res);
      logic exp_zero;
      exp_zero = (exp_res == '0);
      compared++;
      if (res !== exp_res) begin
         mismatched++;
         $display("FAIL %s: code=%b A=%h B=%h result actual=%h expected=%h",
                  tag, op, a, b, res, exp_res);
      end
      compared++;
      if (zero !== exp_zero) begin
         mismatched++;
         $display("FAIL R8 (%s): code=%b A=%h B=%h zero actual=%b expected=%b",
                  tag, op, a, b, zero, exp_zero);
      end
   endtask

   task automatic apply(input logic [2:0] c, input logic [W-1:0] x,
                        input logic [W-1:0] y, input logic [W-1:0] e);
      @(posedge clk);
      op = c; a = x; b = y;
      @(negedge clk);
      check(tag_of(c), e);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
                  compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=expired expected=done");
      summary();
   end

   initial begin
      op = 3'b000; a = '0; b = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: all-zero inputs under AND give a zero result, zero flag set (R3, R8)
      check("R3", '0);
      rst = 1'b0;

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][98:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
      end

      // R7: both unused codes across distinct operand patterns
      apply(3'b100, 32'h0000_0000, 32'h0000_0001, '0);
      apply(3'b101, 32'h8000_0000, 32'h7FFF_FFFF, '0);

      // R6: most negative against zero, and zero against most negative
      apply(3'b111, 32'h8000_0000, 32'h0000_0000, 32'h0000_0001);
      apply(3'b111, 32'h0000_0000, 32'h8000_0000, 32'h0000_0000);

      // R9: inputs change between edges, outputs follow with no clock edge
      @(negedge clk);
      #1; op = 3'b010; a = 32'h0000_0010; b = 32'h0000_0020;
      #1; check("R9", 32'h0000_0030);
      a = 32'hFFFF_FFE0;
      #1; check("R9", 32'h0000_0000);
      op = 3'b011;
      #1; check("R9", 32'hFFFF_FFC0);

      // pseudo-random sweep against the bench model
      for (int i = 0; i < NRAND; i++) begin
         logic [2:0]   c;
         logic [W-1:0] x;
         logic [W-1:0] y;
         c = 3'($urandom);
         x = $urandom;
         y = (i % 7 == 0) ? x : $urandom;
         if (i % 11 == 0) x = {x[W-1], {(W-1){~x[W-1]}}};
         apply(c, x, y, model(c, x, y));
      end

      summary();
   end

endmodule